// File: doc/BRIEF.md
# Inbound Snoop and Retry Sequencer

This block orders the coherence checks for a memory burst that a PCI master has started toward system memory. When the burst is claimed, it captures the start address. It then sends a snoop request to the CPU bus for the cache block that holds that address and holds off data beats until the CPU side answers. Beats then flow, and the address moves forward by 4 bytes on each accepted beat. When a beat carries the address over a 32-byte cache block boundary, the block stalls the burst again and snoops the new block before any more data moves.

A snoop answered with a hit means a processor holds a modified copy. In that case the block ends the PCI transaction with a one-cycle retry command. It then grants the CPU bus to the processor for a fixed number of cycles so the dirty line can be pushed out. The block then returns to idle, and the master must arbitrate again and re-issue the access. Only one snoop is ever outstanding. A claim that arrives while a burst, a retry or a push grant is in progress is ignored.

Top module: `snoop_retry_seq`

## Requirements
- R1: While rst_ni is low, snp_req_o, beat_ready_o, pci_retry_o and cpu_grant_o are low and snp_addr_o is zero.
- R2: A claim_i pulse while idle captures start_addr_i. In the following cycle the block raises snp_req_o for exactly one cycle, with snp_addr_o equal to start_addr_i with its low 5 bits cleared.
- R3: From the snoop request cycle until the cycle after the acknowledge, beat_ready_o stays low and beat_i and last_i have no effect on the burst address.
- R4: An acknowledge with snp_hit_i low raises beat_ready_o from the next cycle. Each cycle with beat_i and beat_ready_o both high accepts one beat and advances the burst address by 4.
- R5: An accepted beat with last_i low whose address has bits [4:2] equal to 7 drops beat_ready_o. In the next cycle it issues a one-cycle snoop whose snp_addr_o is the next 32-byte aligned block.
- R6: An accepted beat with last_i high ends the burst. The block returns to idle with no further snoop, and a final beat at block offset 7 issues no snoop.
- R7: An acknowledge with snp_hit_i high raises pci_retry_o for exactly one cycle in the next cycle, and no beat is accepted after it.
- R8: The cycle after pci_retry_o, cpu_grant_o goes high for PUSH_CYC consecutive cycles (default 4) and then low, and the block is idle again.
- R9: claim_i is ignored whenever the block is not idle, including during the retry and push grant cycles. It starts no new snoop and does not change the burst address.
- R10: Only one snoop is outstanding at a time. snp_req_o is never high in two consecutive cycles, and no new request is issued before the previous one is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| claim_i | input | 1 | Inbound memory access claimed, start pulse |
| start_addr_i | input | AW | Byte address of the first beat |
| beat_i | input | 1 | Master presents a data beat |
| last_i | input | 1 | Presented beat is the final one of the burst |
| snp_ack_i | input | 1 | Snoop response valid |
| snp_hit_i | input | 1 | Snoop response is a hit (address retry); valid with snp_ack_i |
| snp_req_o | output | 1 | Snoop request, one-cycle pulse |
| snp_addr_o | output | AW | Cache-block-aligned snoop address |
| beat_ready_o | output | 1 | Target ready; a beat is accepted when beat_i is also high |
| pci_retry_o | output | 1 | Terminate the PCI transaction with retry |
| cpu_grant_o | output | 1 | CPU bus granted to the processor for a snoop push |

## Verification
The checks assume the CPU side sends exactly one snp_ack_i for each snp_req_o, no earlier than the cycle after the request and never with no request outstanding. snp_hit_i is taken as meaningful only together with that acknowledge. The stimulus answers each request after a chosen delay of zero to two cycles, raising the hit only on the planned snoop. It keeps beat_i and last_i asserted while the block is stalling, so that a wrongly accepted beat would shift the later snoop addresses. A noisy claim run holds claim_i high through a burst and through a retry and grant. It stops only once the block has reached its final cycle before idle, so the design never sees a claim it should accept at an edge the bench did not plan for.

// File: rtl/snp_seq_pkg.sv
package snp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SNOOP,
    ST_WAIT_RESP,
    ST_XFER,
    ST_RETRY,
    ST_PUSH_GRANT
  } seq_state_e;
endpackage

// File: rtl/snp_addr_trk.sv
module snp_addr_trk #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          adv_i,
  output logic [AW-1:0] blk_addr_o,
  output logic          blk_end_o
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (adv_i)  addr_q <= addr_q + AW'(4);
  end

  // last word slot of the current block
  assign blk_end_o  = &addr_q[OFF_W-1:2];
  assign blk_addr_o = {addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};

  // R4
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> addr_q == $past(addr_q) + AW'(4));
  // R2
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_q == $past(load_addr_i));
  // R9
  load_adv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i));
endmodule

// File: rtl/snp_push_tmr.sv
module snp_push_tmr #(
  parameter int PUSH_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(PUSH_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + CW'(1);
    else            cnt_q <= '0;
  end

  assign done_o = en_i && (cnt_q == CW'(PUSH_CYC - 1));

  // R8
  push_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < CW'(PUSH_CYC));
endmodule

// File: rtl/snp_seq_ctrl.sv
module snp_seq_ctrl
  import snp_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic claim_i,
  input  logic beat_i,
  input  logic last_i,
  input  logic snp_ack_i,
  input  logic snp_hit_i,
  input  logic blk_end_i,
  input  logic push_done_i,
  output logic load_o,
  output logic adv_o,
  output logic snp_req_o,
  output logic beat_ready_o,
  output logic pci_retry_o,
  output logic cpu_grant_o,
  output logic push_en_o
);
  seq_state_e st_q, st_d;
  logic acc;

  assign acc = (st_q == ST_XFER) && beat_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:       if (claim_i) st_d = ST_SNOOP;
      ST_SNOOP:      st_d = ST_WAIT_RESP;
      ST_WAIT_RESP:  if (snp_ack_i) st_d = snp_hit_i ? ST_RETRY : ST_XFER;
      ST_XFER: begin
        if (acc) begin
          if (last_i)         st_d = ST_IDLE;
          else if (blk_end_i) st_d = ST_SNOOP;
        end
      end
      ST_RETRY:      st_d = ST_PUSH_GRANT;
      ST_PUSH_GRANT: if (push_done_i) st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign load_o       = (st_q == ST_IDLE) && claim_i;
  assign adv_o        = acc && !last_i;
  assign snp_req_o    = (st_q == ST_SNOOP);
  assign beat_ready_o = (st_q == ST_XFER);
  assign pci_retry_o  = (st_q == ST_RETRY);
  assign cpu_grant_o  = (st_q == ST_PUSH_GRANT);
  assign push_en_o    = cpu_grant_o;

  // R3
  snoop_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_req_o |=> !beat_ready_o);
  // R10
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_req_o |=> !snp_req_o);
  // R5
  cross_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !last_i && blk_end_i |=> snp_req_o && !beat_ready_o);
  // R6
  last_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && last_i |=> !snp_req_o && !beat_ready_o);
  // R7
  hit_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_RESP) && snp_ack_i && snp_hit_i |=> pci_retry_o && !beat_ready_o);
  // R7
  retry_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_retry_o |=> !pci_retry_o);
  // R8
  retry_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_retry_o |=> cpu_grant_o);
  // R10: responder protocol, ack only while a snoop is outstanding
  ack_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_ack_i |-> st_q == ST_WAIT_RESP);
endmodule

// File: rtl/snoop_retry_seq.sv
module snoop_retry_seq #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 32,
  parameter int PUSH_CYC  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          claim_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          beat_i,
  input  logic          last_i,
  input  logic          snp_ack_i,
  input  logic          snp_hit_i,
  output logic          snp_req_o,
  output logic [AW-1:0] snp_addr_o,
  output logic          beat_ready_o,
  output logic          pci_retry_o,
  output logic          cpu_grant_o
);
  logic load, adv, blk_end, push_en, push_done;

  snp_addr_trk #(.AW(AW), .BLK_BYTES(BLK_BYTES)) addr_trk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (start_addr_i),
    .adv_i       (adv),
    .blk_addr_o  (snp_addr_o),
    .blk_end_o   (blk_end)
  );

  snp_seq_ctrl ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .claim_i      (claim_i),
    .beat_i       (beat_i),
    .last_i       (last_i),
    .snp_ack_i    (snp_ack_i),
    .snp_hit_i    (snp_hit_i),
    .blk_end_i    (blk_end),
    .push_done_i  (push_done),
    .load_o       (load),
    .adv_o        (adv),
    .snp_req_o    (snp_req_o),
    .beat_ready_o (beat_ready_o),
    .pci_retry_o  (pci_retry_o),
    .cpu_grant_o  (cpu_grant_o),
    .push_en_o    (push_en)
  );

  snp_push_tmr #(.PUSH_CYC(PUSH_CYC)) push_tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (push_en),
    .done_o (push_done)
  );

  // R1
  out_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({snp_req_o, beat_ready_o, pci_retry_o, cpu_grant_o}));
  // R8
  grant_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_done |=> !cpu_grant_o && !snp_req_o);
endmodule

// File: tb/snoop_retry_seq_tb_top.sv
`timescale 1ns/1ps
module snoop_retry_seq_tb_top;
  localparam int AW   = 32;
  localparam int PUSH = 4;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic rst_ni, claim_i, beat_i, last_i, snp_ack_i, snp_hit_i;
  logic [AW-1:0] start_addr_i, snp_addr_o;
  logic snp_req_o, beat_ready_o, pci_retry_o, cpu_grant_o;

  snoop_retry_seq #(.AW(AW), .BLK_BYTES(32), .PUSH_CYC(PUSH)) dut_i (.*);

  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R6 watchdog act=%0d exp<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // start address, beats, snoop index that hits (-1 none), ack delay
  localparam logic [31:0] V_ADDR [8] = '{32'h1000, 32'h101C, 32'h2000, 32'h3010,
                                         32'h4000, 32'h5018, 32'h6004, 32'h701C};
  localparam int V_N   [8] = '{4, 3, 20, 9, 4, 10, 1, 1};
  localparam int V_HIT [8] = '{-1, -1, -1, -1, 0, 1, -1, -1};
  localparam int V_DLY [8] = '{0, 1, 0, 2, 0, 1, 2, 0};

  task automatic run_burst(input logic [31:0] a, input int n, input int hit,
                           input int dly, input bit noisy);
    logic [31:0] exp_snp [32];
    logic [31:0] pa;
    int exp_cnt, exp_beats;
    int left, done, sc, rty, gnt, quiet, stall, wcnt, iter;
    bit ackp;
    // expected model
    pa = a; exp_cnt = 1; exp_snp[0] = {a[31:5], 5'b0}; exp_beats = -1;
    if (hit == 0) exp_beats = 0;
    else begin
      for (int i = 0; i < n - 1; i++) begin
        pa = pa + 32'd4;
        if (pa[4:0] == 5'd0) begin
          exp_snp[exp_cnt] = pa;
          if (exp_cnt == hit) begin
            exp_beats = i + 1; exp_cnt++;
            break;
          end
          exp_cnt++;
        end
      end
    end
    if (exp_beats < 0) exp_beats = n;
    // drive
    @(negedge clk_i);
    claim_i = 1'b1; start_addr_i = a;
    left = n; done = 0; sc = 0; rty = 0; gnt = 0; quiet = 0; stall = 0;
    wcnt = 0; iter = 0; ackp = 1'b0;
    while (quiet < 3 && iter < 500) begin
      @(negedge clk_i);
      iter++;
      claim_i = 1'b0; snp_ack_i = 1'b0; snp_hit_i = 1'b0; beat_i = 1'b0; last_i = 1'b0;
      if (ackp) begin
        if (wcnt == 0) begin
          snp_ack_i = 1'b1; snp_hit_i = (sc - 1 == hit); ackp = 1'b0;
        end else wcnt--;
      end
      if (beat_ready_o && (ackp || snp_req_o)) stall++;
      if (snp_req_o) begin
        if (sc < exp_cnt) chk(sc == 0 ? "R2 first snoop addr" : "R5 crossing snoop addr",
                              snp_addr_o, exp_snp[sc]);
        sc++; ackp = 1'b1; wcnt = dly;
      end
      if (left > 0) begin
        // beats stay offered while stalled (R3)
        beat_i = 1'b1; last_i = (left == 1);
        if (beat_ready_o) begin done++; left--; end
      end
      if (pci_retry_o) rty++;
      if (cpu_grant_o) gnt++;
      if (noisy && !(left == 0 && hit < 0) && gnt < PUSH) begin
        claim_i = 1'b1; start_addr_i = 32'h0009_0000;
      end
      if (!snp_req_o && !beat_ready_o && !pci_retry_o && !cpu_grant_o && !ackp &&
          !snp_ack_i && (left == 0 || rty > 0)) quiet++;
      else quiet = 0;
    end
    claim_i = 1'b0; beat_i = 1'b0; last_i = 1'b0; snp_ack_i = 1'b0; snp_hit_i = 1'b0;
    chk(noisy ? "R9 snoop count under claim noise" : "R5 R6 R10 snoop count", sc, exp_cnt);
    chk("R4 R6 beats accepted", done, exp_beats);
    chk("R3 no ready while snoop pending", stall, 0);
    chk("R7 retry pulses", rty, (hit >= 0) ? 1 : 0);
    chk("R8 grant cycles", gnt, (hit >= 0) ? PUSH : 0);
  endtask

  initial begin
    rst_ni = 1'b0; claim_i = 1'b0; beat_i = 1'b0; last_i = 1'b0;
    snp_ack_i = 1'b0; snp_hit_i = 1'b0; start_addr_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs in reset",
        {28'd0, snp_req_o, beat_ready_o, pci_retry_o, cpu_grant_o}, 32'd0);
    chk("R1 snoop addr in reset", snp_addr_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < 8; v++) run_burst(V_ADDR[v], V_N[v], V_HIT[v], V_DLY[v], 1'b0);

    // R9 claims held through a burst, then through a retry and push
    run_burst(32'h8018, 6, -1, 1, 1'b1);
    run_burst(32'hA000, 12, 1, 0, 1'b1);

    // R6 idle after completion: no spontaneous snoop
    repeat (4) @(negedge clk_i);
    chk("R6 no snoop while idle", {31'd0, snp_req_o}, 32'd0);

    // R1 reset taken mid-burst
    @(negedge clk_i); claim_i = 1'b1; start_addr_i = 32'hB000;
    @(negedge clk_i); claim_i = 1'b0;
    @(negedge clk_i); snp_ack_i = 1'b1;
    @(negedge clk_i); snp_ack_i = 1'b0;
    chk("R4 ready after clean ack", {31'd0, beat_ready_o}, 32'd1);
    rst_ni = 1'b0;
    #1;
    chk("R1 outputs after async reset",
        {28'd0, snp_req_o, beat_ready_o, pci_retry_o, cpu_grant_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule